// File: doc/BRIEF.md
# Grouped 32-bit Carry Lookahead Adder

The block adds two 32-bit operands and a carry-in, and returns a 32-bit sum and a carry-out. Its carry network is built only from lookahead cells that combine at most four terms each, arranged in four layers:
- **Bit layer.** Each bit position produces generate, propagate and kill flags.
- **Group layer.** Cells over nibbles (4-bit groups) form group flags and the carry out of the lowest nibble.
- **Carry layer.** Cells over whole nibbles produce the carries at bits 8, 12 and 16. From bit 16 they also form long-range span terms that reach to bits 19, 23, 27 and 31, and these terms give the remaining nibble carries and the final carry.
- **Sum layer.** Each sum bit is its propagate flag XORed with the carry into that bit.

Propagate is an exclusive-OR. As a result the three flags of any bit, nibble or span are mutually exclusive, and exactly one of them is true.

The combinational core sits between an input register stage and an output register stage. Both stages run on one clock and have a synchronous active-high reset, so a result appears two rising edges after its operands are presented.

For checking, the block also exposes the per-nibble flags and the carry into each nibble, registered together with the sum. There is no state machine. The only state is the two register stages:
- **RESET.** While reset is high, every register is cleared.
- **RUN.** Otherwise, every register loads on each edge.

Top module: `cla_adder32`

## Requirements
- R1: While reset is high at a rising edge, the next values of sum, carry_out and all four debug vectors are zero.
- R2: When operands a, b and carry-in c are applied before rising edge n, the value {carry_out, sum} seen after edge n+1 equals a + b + c, taken as a 33-bit unsigned value.
- R3: Nibble j covers bits 4j+3..4j. The flags for nibble j appear after edge n+1 as follows:
  - dbg_grp_gen[j] is 1 exactly when the two 4-bit slices add to 16 or more.
  - dbg_grp_prop[j] is 1 exactly when the slices add to 15.
  - dbg_grp_kill[j] is 1 exactly when the slices add to 14 or less.
- R4: For every nibble, exactly one of dbg_grp_gen[j], dbg_grp_prop[j] and dbg_grp_kill[j] is 1. The same holds for every bit and every span term inside the carry network.
- R5: dbg_grp_cin[j] is the carry into bit 4j. Bit 0 is carry_in. For j ≥ 1 it is bit 4j of (a mod 2^4j) + (b mod 2^4j) + c.
- R6: carry_out equals the carry out of bit 31. It agrees with the carry that ripples through the top nibble bit by bit.
- R7: Each of the following produces the arithmetically correct sum and carry-out:
  - a full-length carry ripple (all-ones plus carry-in 1);
  - all-ones plus all-ones;
  - alternating bit patterns;
  - carries that stop exactly at a nibble boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers load on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Registered sum |
| carry_out | output | 1 | Registered carry out of bit 31 |
| dbg_grp_gen | output | 8 | Registered generate flag for each nibble |
| dbg_grp_prop | output | 8 | Registered propagate flag for each nibble |
| dbg_grp_kill | output | 8 | Registered kill flag for each nibble |
| dbg_grp_cin | output | 8 | Registered carry into each nibble, bit 0 being carry_in |

## Verification
The hardest situation to reach from the ports is a carry that must cross the long-range span terms: every nibble above bit 16 propagates, so the final carry depends only on c16 passing through the spans. Random operands almost never do this. The stimulus therefore uses directed all-ones operands with each carry-in value, and operands whose nibbles sum to exactly 15 above a generating low half. It also uses patterns that generate in one nibble and kill in the next, so that each carry stops at a chosen boundary. Every cycle the bench compares the nibble flags and nibble carries against slice arithmetic, so a wrong carry is seen at the nibble where it first goes wrong, not only in the final sum.

// File: rtl/cla_pkg.sv
package cla_pkg;

    // Nibble size of a lookahead group; the network layout assumes 32 bits.
    localparam int GRP_W   = 4;
    localparam int DATA_W  = 32;
    localparam int NGRP    = DATA_W / GRP_W;
    localparam int HALF_G  = NGRP / 2;

    // Generate / propagate / kill triple; exactly one field is set.
    typedef struct packed {
        logic gen;
        logic prop;
        logic kill;
    } gpk_t;

    // Per-bit flags: propagate is XOR so the triple stays exclusive.
    function automatic gpk_t bit_flags(input logic a, input logic b);
        gpk_t f;
        f.gen  = a & b;
        f.prop = a ^ b;
        f.kill = ~(a | b);
        return f;
    endfunction

    // Merge a higher span onto a lower adjacent span.
    function automatic gpk_t merge_span(input gpk_t hi, input gpk_t lo);
        gpk_t f;
        f.gen  = hi.gen  | (hi.prop & lo.gen);
        f.prop = hi.prop & lo.prop;
        f.kill = hi.kill | (hi.prop & lo.kill);
        return f;
    endfunction

endpackage

// File: rtl/cla_bit_cell.sv
module cla_bit_cell
    import cla_pkg::*;
(
    input  logic a,
    input  logic b,
    output gpk_t flags
);

    assign flags = bit_flags(a, b);

endmodule

// File: rtl/cla_lookahead.sv
// Multi-output lookahead cell over at most four adjacent terms.
// span  : combined flags of all N terms
// cout  : carry out of each term, given the carry into term 0
module cla_lookahead
    import cla_pkg::*;
#(
    parameter int N = 4
) (
    input  gpk_t [N-1:0] term,
    input  logic         cin,
    output gpk_t         span,
    output logic [N-1:0] cout
);

    gpk_t [N-1:0] pre;

    assign pre[0] = term[0];

    generate
        for (genvar j = 1; j < N; j++) begin : g_pre
            assign pre[j] = merge_span(term[j], pre[j-1]);
        end
        for (genvar j = 0; j < N; j++) begin : g_cout
            assign cout[j] = pre[j].gen | (pre[j].prop & cin);
        end
    endgenerate

    assign span = pre[N-1];

    always_comb begin
        for (int j = 0; j < N; j++) begin
            p_term_onehot_r4: assert ($onehot({term[j].gen, term[j].prop, term[j].kill}));
            p_prefix_onehot_r4: assert ($onehot({pre[j].gen, pre[j].prop, pre[j].kill}));
        end
    end

endmodule

// File: rtl/cla32_core.sv
// Four-layer combinational carry lookahead network.
module cla32_core
    import cla_pkg::*;
(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout,
    output logic [NGRP-1:0]   grp_gen,
    output logic [NGRP-1:0]   grp_prop,
    output logic [NGRP-1:0]   grp_kill,
    output logic [NGRP-1:0]   grp_cin
);

    gpk_t [DATA_W-1:0]   bitf;
    gpk_t [NGRP-1:0]     grp;
    logic [DATA_W-1:0]   bit_cout;
    logic [DATA_W-1:0]   bit_cin;
    logic [HALF_G-2:0]   c_mid;
    logic [HALF_G-1:0]   c_hi;
    gpk_t                mid_span;
    gpk_t                hi_span;

    // Layer 1: per-bit flags
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            cla_bit_cell u_bit (
                .a     (a[i]),
                .b     (b[i]),
                .flags (bitf[i])
            );
        end
    endgenerate

    // Layer 2 (and in-nibble carries for layer 4): one cell per nibble
    generate
        for (genvar j = 0; j < NGRP; j++) begin : g_grp
            cla_lookahead #(.N(GRP_W)) u_grp (
                .term (bitf[GRP_W*j +: GRP_W]),
                .cin  (grp_cin[j]),
                .span (grp[j]),
                .cout (bit_cout[GRP_W*j +: GRP_W])
            );
        end
    endgenerate

    // Layer 3a: carries at 8, 12, 16 from the carry at 4
    cla_lookahead #(.N(HALF_G-1)) u_mid (
        .term (grp[HALF_G-1:1]),
        .cin  (grp_cin[1]),
        .span (mid_span),
        .cout (c_mid)
    );

    // Layer 3b: spans from bit 16 to 19, 23, 27, 31; carries 20..32
    cla_lookahead #(.N(HALF_G)) u_hi (
        .term (grp[NGRP-1:HALF_G]),
        .cin  (grp_cin[HALF_G]),
        .span (hi_span),
        .cout (c_hi)
    );

    always_comb begin
        grp_cin[0] = cin;
        grp_cin[1] = bit_cout[GRP_W-1];
        for (int j = 0; j < HALF_G-1; j++) begin
            grp_cin[j+2] = c_mid[j];
        end
        for (int j = 0; j < HALF_G-1; j++) begin
            grp_cin[HALF_G+1+j] = c_hi[j];
        end
    end

    assign cout = c_hi[HALF_G-1];

    always_comb begin
        for (int j = 0; j < NGRP; j++) begin
            grp_gen[j]  = grp[j].gen;
            grp_prop[j] = grp[j].prop;
            grp_kill[j] = grp[j].kill;
        end
    end

    // Layer 4: sum stage
    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            if ((i % GRP_W) == 0) bit_cin[i] = grp_cin[i / GRP_W];
            else                  bit_cin[i] = bit_cout[i-1];
            sum[i] = bitf[i].prop ^ bit_cin[i];
        end
    end

    // Checks across separately built parts of the network
    always_comb begin
        p_sum_value_r2: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin}));
        p_cout_ripple_r6: assert (cout == bit_cout[DATA_W-1]);
        p_span_onehot_r4: assert ($onehot({mid_span.gen, mid_span.prop, mid_span.kill})
                                  && $onehot({hi_span.gen, hi_span.prop, hi_span.kill}));
        for (int j = 1; j < NGRP; j++) begin
            p_grp_carry_r5: assert (grp_cin[j] == bit_cout[GRP_W*j-1]);
        end
        for (int j = 0; j < NGRP; j++) begin
            p_grp_onehot_r4: assert ($onehot({grp_gen[j], grp_prop[j], grp_kill[j]}));
        end
    end

endmodule

// File: rtl/cla_adder32.sv
// Registered wrapper: input stage, lookahead core, output stage.
module cla_adder32
    import cla_pkg::*;
#(
    parameter int WIDTH = DATA_W,
    localparam int NG   = WIDTH / GRP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out,
    output logic [NG-1:0]    dbg_grp_gen,
    output logic [NG-1:0]    dbg_grp_prop,
    output logic [NG-1:0]    dbg_grp_kill,
    output logic [NG-1:0]    dbg_grp_cin
);

    logic [WIDTH-1:0] a_q;
    logic [WIDTH-1:0] b_q;
    logic             cin_q;

    logic [WIDTH-1:0] core_sum;
    logic             core_cout;
    logic [NG-1:0]    core_gen;
    logic [NG-1:0]    core_prop;
    logic [NG-1:0]    core_kill;
    logic [NG-1:0]    core_cin;

    // Input stage
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q   <= '0;
            b_q   <= '0;
            cin_q <= 1'b0;
        end else begin
            a_q   <= op_a;
            b_q   <= op_b;
            cin_q <= carry_in;
        end
    end

    cla32_core u_core (
        .a        (a_q),
        .b        (b_q),
        .cin      (cin_q),
        .sum      (core_sum),
        .cout     (core_cout),
        .grp_gen  (core_gen),
        .grp_prop (core_prop),
        .grp_kill (core_kill),
        .grp_cin  (core_cin)
    );

    // Output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            sum          <= '0;
            carry_out    <= 1'b0;
            dbg_grp_gen  <= '0;
            dbg_grp_prop <= '0;
            dbg_grp_kill <= '0;
            dbg_grp_cin  <= '0;
        end else begin
            sum          <= core_sum;
            carry_out    <= core_cout;
            dbg_grp_gen  <= core_gen;
            dbg_grp_prop <= core_prop;
            dbg_grp_kill <= core_kill;
            dbg_grp_cin  <= core_cin;
        end
    end

endmodule

// File: tb/cla_adder32_tb.sv
module cla_adder32_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        carry_in = 1'b0;
    logic [31:0] sum;
    logic        carry_out;
    logic [7:0]  dbg_grp_gen;
    logic [7:0]  dbg_grp_prop;
    logic [7:0]  dbg_grp_kill;
    logic [7:0]  dbg_grp_cin;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [31:0] ha[$];
    logic [31:0] hb[$];
    logic        hc[$];

    always #5 clk = ~clk;

    cla_adder32 dut_i (
        .clk          (clk),
        .rst          (rst),
        .op_a         (op_a),
        .op_b         (op_b),
        .carry_in     (carry_in),
        .sum          (sum),
        .carry_out    (carry_out),
        .dbg_grp_gen  (dbg_grp_gen),
        .dbg_grp_prop (dbg_grp_prop),
        .dbg_grp_kill (dbg_grp_kill),
        .dbg_grp_cin  (dbg_grp_cin)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference: compare outputs against operands applied two edges earlier
    task automatic compare(input logic [31:0] a, input logic [31:0] b, input logic c);
        longint full;
        logic [7:0] eg, ep, ek, ec;
        logic [7:0] oh;
        full = longint'(a) + longint'(b) + longint'(c);
        for (int j = 0; j < 8; j++) begin
            int s;
            longint mask;
            s = int'((a >> (4*j)) & 32'hF) + int'((b >> (4*j)) & 32'hF);
            eg[j] = (s > 15);
            ep[j] = (s == 15);
            ek[j] = (s < 15);
            mask = (longint'(1) << (4*j)) - 1;
            ec[j] = (((longint'(a) & mask) + (longint'(b) & mask) + longint'(c)) >> (4*j)) & 1;
            oh[j] = ((dbg_grp_gen[j] + dbg_grp_prop[j] + dbg_grp_kill[j]) == 1);
        end
        chk("R2 sum", longint'(sum), full & 64'hFFFF_FFFF);
        chk("R6 carry_out", longint'(carry_out), (full >> 32) & 1);
        chk("R3 grp flags", longint'({dbg_grp_gen, dbg_grp_prop, dbg_grp_kill}),
            longint'({eg, ep, ek}));
        chk("R4 grp onehot", longint'(oh), 64'hFF);
        chk("R5 grp carries", longint'(dbg_grp_cin), longint'(ec));
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic c);
        @(negedge clk);
        if (ha.size() == 2) begin
            compare(ha[0], hb[0], hc[0]);
            void'(ha.pop_front());
            void'(hb.pop_front());
            void'(hc.pop_front());
        end
        ha.push_back(a);
        hb.push_back(b);
        hc.push_back(c);
        op_a     = a;
        op_b     = b;
        carry_in = c;
    endtask

    initial begin
        // R1: reset clears outputs even with nonzero inputs present
        op_a = 32'hFFFF_FFFF;
        op_b = 32'h1234_5678;
        carry_in = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R1 sum", longint'(sum), 0);
        chk("R1 carry_out", longint'(carry_out), 0);
        chk("R1 dbg", longint'({dbg_grp_gen, dbg_grp_prop, dbg_grp_kill, dbg_grp_cin}), 0);
        rst = 1'b0;

        // R7 directed corner cases
        apply(32'h0000_0000, 32'h0000_0000, 1'b0);
        apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b1);   // R7 full ripple
        apply(32'hFFFF_FFFF, 32'h0000_0000, 1'b0);   // R7 all propagate, no carry
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0);   // R7 all ones
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b0);   // R7 alternating
        apply(32'h5555_5555, 32'hAAAA_AAAA, 1'b1);
        apply(32'hAAAA_AAAA, 32'hAAAA_AAAA, 1'b0);
        apply(32'h5555_5555, 32'h5555_5555, 1'b1);
        apply(32'h0000_000F, 32'h0000_0001, 1'b0);   // R7 carry stops at nibble 1
        apply(32'h0000_FFFF, 32'h0000_0001, 1'b0);   // R7 carry reaches bit 16
        apply(32'hFFFF_0000, 32'h0000_8000, 1'b0);
        apply(32'hFFFF_8000, 32'h0000_8000, 1'b0);   // R7 spans above bit 16 all propagate
        apply(32'h7FFF_FFFF, 32'h0000_0001, 1'b0);
        apply(32'h8000_0000, 32'h8000_0000, 1'b0);
        apply(32'h0F0F_0F0F, 32'h0F0F_0F0F, 1'b1);
        apply(32'h1234_5678, 32'hEDCB_A987, 1'b1);   // nibbles sum to 15

        // Random operands, with some high-propagate bias
        for (int k = 0; k < 400; k++) begin
            logic [31:0] ra, rb;
            ra = $urandom();
            rb = $urandom();
            if (k % 4 == 1) rb = ~ra;
            if (k % 4 == 2) rb = {~ra[31:16], rb[15:0]};
            apply(ra, rb, 1'(($urandom() & 1)));
        end
        apply(32'h0, 32'h0, 1'b0);
        apply(32'h0, 32'h0, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog R2 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule